// File: doc/BRIEF.md
# Outbound Address Translation Region Table

This block holds a small set of programmable windows that redirect outgoing local bus addresses into link-side addresses. Each window has a 64-bit base, an inclusive limit, a 64-bit target and a transaction-type code. The code marks an access as memory, I/O, type-0 configuration or type-1 configuration. Software programs the windows through a 32-bit register port. Writes take effect at the clock edge, and reads return data combinationally from the word address.

A lookup is purely combinational. An address presented with its valid strobe returns four results:
- whether an enabled window claims it;
- the rewritten address, which is the window target plus the request's offset from the window base;
- the window's type code;
- the number of the claiming window.

When windows overlap, the lowest-numbered one wins. A request that no window claims passes through unchanged. A per-window extended-size bit widens the limit compare to the full 64 bits, for windows larger than 4 GiB.

Top module: `otr_table`

## Requirements
- R1: After reset every register reads zero, every window is disabled and no request hits.
- R2: The word address is split as {window[2:0], word[5:0]}, so each window occupies 0x100 bytes. Each word reads back what was last written to it. The word indices are: 0 control-1, 1 control-2, 2 base low, 3 base high, 4 limit low, 5 target low, 6 target high, 8 limit high.
- R3: Control-1 keeps only bits [4:0] (type) and bit 13 (extended size), and control-2 keeps only bit 31 (enable). All other bits, and unassigned words, read zero. An enable written is seen on the next cycle.
- R4: A window whose enable bit is clear never matches.
- R5: Bounds are inclusive. An address equal to the base or to the limit hits, and base-1 or limit+1 misses.
- R6: The output address is target + (address - base), computed over 64 bits. For configuration windows this keeps bus[31:24], device[23:19] and function[18:16] of the target.
- R7: With extended size off, address[63:32] must equal base[63:32], and address[31:0] is compared with limit low. With it on, the address is compared with the full {limit high, limit low}.
- R8: Among several matching windows, the lowest index is reported.
- R9: On a miss, hit is low, the output address equals the request address, and type and index are zero.
- R10: The type output is the claiming window's code: 0 memory, 2 I/O, 4 configuration type 0, 5 configuration type 1.
- R11: With the request valid low, hit stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 9 | Word address {window, word} |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i |
| req_valid_i | input | 1 | Request valid |
| req_addr_i | input | 64 | Local address to translate |
| hit_o | output | 1 | A window claimed the request |
| xlat_addr_o | output | 64 | Translated address, or the request address on a miss |
| type_o | output | 5 | Transaction type of the claiming window |
| region_o | output | 3 | Index of the claiming window |

## Verification
Several properties are checked on every cycle:
- a miss passes the address through with zero type and index;
- no hit is reported without valid;
- a reported window is enabled, matches, and has no lower-numbered window also matching;
- a write to a control-2 word sets or clears that window's enable on the next cycle.

Other behaviours can only be shown by the bench's scenarios, because the per-window compares are the thing under test. These are the exact inclusive bound edges, the 64-bit offset arithmetic, the upper-word rule with extended size off versus on, field masking and register readback.

// File: rtl/otr_pkg.sv
package otr_pkg;
  localparam int REG_W  = 32;
  localparam int LA_W   = 64;
  localparam int TYPE_W = 5;

  localparam int W_CTRL1    = 0;
  localparam int W_CTRL2    = 1;
  localparam int W_BASE_LO  = 2;
  localparam int W_BASE_HI  = 3;
  localparam int W_LIM_LO   = 4;
  localparam int W_TGT_LO   = 5;
  localparam int W_TGT_HI   = 6;
  localparam int W_LIM_HI   = 8;

  localparam int EXT_BIT = 13;
  localparam int EN_BIT  = 31;

  localparam logic [TYPE_W-1:0] T_MEM  = 5'd0;
  localparam logic [TYPE_W-1:0] T_IO   = 5'd2;
  localparam logic [TYPE_W-1:0] T_CFG0 = 5'd4;
  localparam logic [TYPE_W-1:0] T_CFG1 = 5'd5;
endpackage

// File: rtl/otr_region.sv
module otr_region
  import otr_pkg::*;
#(
  parameter int WORD_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  input  logic [LA_W-1:0]   req_addr_i,
  output logic              en_o,
  output logic              match_o,
  output logic [LA_W-1:0]   xlat_o,
  output logic [TYPE_W-1:0] type_o
);
  localparam int HALF = LA_W / 2;

  logic [TYPE_W-1:0] type_q;
  logic              ext_q, en_q;
  logic [LA_W-1:0]   base_q, target_q;
  logic [HALF-1:0]   lim_lo_q, lim_hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      type_q   <= '0;
      ext_q    <= 1'b0;
      en_q     <= 1'b0;
      base_q   <= '0;
      target_q <= '0;
      lim_lo_q <= '0;
      lim_hi_q <= '0;
    end else if (wr_i) begin
      case (int'(word_i))
        W_CTRL1: begin
          type_q <= wdata_i[TYPE_W-1:0];
          ext_q  <= wdata_i[EXT_BIT];
        end
        W_CTRL2:   en_q               <= wdata_i[EN_BIT];
        W_BASE_LO: base_q[HALF-1:0]   <= wdata_i;
        W_BASE_HI: base_q[LA_W-1:HALF] <= wdata_i;
        W_LIM_LO:  lim_lo_q           <= wdata_i;
        W_TGT_LO:  target_q[HALF-1:0] <= wdata_i;
        W_TGT_HI:  target_q[LA_W-1:HALF] <= wdata_i;
        W_LIM_HI:  lim_hi_q           <= wdata_i;
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    case (int'(word_i))
      W_CTRL1: begin
        rdata_o[TYPE_W-1:0] = type_q;
        rdata_o[EXT_BIT]    = ext_q;
      end
      W_CTRL2:   rdata_o[EN_BIT] = en_q;
      W_BASE_LO: rdata_o = base_q[HALF-1:0];
      W_BASE_HI: rdata_o = base_q[LA_W-1:HALF];
      W_LIM_LO:  rdata_o = lim_lo_q;
      W_TGT_LO:  rdata_o = target_q[HALF-1:0];
      W_TGT_HI:  rdata_o = target_q[LA_W-1:HALF];
      W_LIM_HI:  rdata_o = lim_hi_q;
      default:   rdata_o = '0;
    endcase
  end

  logic above_base, below_lim;
  always_comb begin
    above_base = req_addr_i >= base_q;
    if (ext_q) below_lim = req_addr_i <= {lim_hi_q, lim_lo_q};
    else       below_lim = (req_addr_i[LA_W-1:HALF] == base_q[LA_W-1:HALF]) &&
                           (req_addr_i[HALF-1:0] <= lim_lo_q);
  end

  assign en_o    = en_q;
  assign match_o = en_q & above_base & below_lim;
  assign xlat_o  = target_q + (req_addr_i - base_q);
  assign type_o  = type_q;
endmodule

// File: rtl/otr_select.sv
module otr_select
  import otr_pkg::*;
#(
  parameter int N_REGIONS = 8,
  parameter int IDX_W     = 3
) (
  input  logic [N_REGIONS-1:0]             match_i,
  input  logic [N_REGIONS-1:0][LA_W-1:0]   xlat_i,
  input  logic [N_REGIONS-1:0][TYPE_W-1:0] type_i,
  input  logic [LA_W-1:0]                  req_addr_i,
  output logic                             hit_o,
  output logic [LA_W-1:0]                  xlat_o,
  output logic [TYPE_W-1:0]                type_o,
  output logic [IDX_W-1:0]                 idx_o
);
  always_comb begin
    hit_o  = 1'b0;
    xlat_o = req_addr_i;
    type_o = '0;
    idx_o  = '0;
    // scan downward so the lowest index is applied last
    for (int i = N_REGIONS - 1; i >= 0; i--) begin
      if (match_i[i]) begin
        hit_o  = 1'b1;
        xlat_o = xlat_i[i];
        type_o = type_i[i];
        idx_o  = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/otr_table.sv
module otr_table
  import otr_pkg::*;
#(
  parameter int N_REGIONS    = 8,
  parameter int STRIDE_BYTES = 256,
  localparam int IDX_W  = $clog2(N_REGIONS),
  localparam int WORD_W = $clog2(STRIDE_BYTES / 4),
  localparam int RA_W   = IDX_W + WORD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [RA_W-1:0]   reg_addr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  input  logic              req_valid_i,
  input  logic [LA_W-1:0]   req_addr_i,
  output logic              hit_o,
  output logic [LA_W-1:0]   xlat_addr_o,
  output logic [TYPE_W-1:0] type_o,
  output logic [IDX_W-1:0]  region_o
);
  logic [IDX_W-1:0]                 wr_rgn;
  logic [WORD_W-1:0]                wr_word;
  logic [N_REGIONS-1:0]             en_vec, raw_match, match_vec;
  logic [N_REGIONS-1:0][LA_W-1:0]   xlat_vec;
  logic [N_REGIONS-1:0][TYPE_W-1:0] type_vec;
  logic [N_REGIONS-1:0][REG_W-1:0]  rdata_vec;

  assign wr_rgn  = reg_addr_i[RA_W-1:WORD_W];
  assign wr_word = reg_addr_i[WORD_W-1:0];

  for (genvar g = 0; g < N_REGIONS; g++) begin : g_rgn
    otr_region #(.WORD_W(WORD_W)) u_rgn (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_i       (reg_we_i && (int'(wr_rgn) == g)),
      .word_i     (wr_word),
      .wdata_i    (reg_wdata_i),
      .rdata_o    (rdata_vec[g]),
      .req_addr_i (req_addr_i),
      .en_o       (en_vec[g]),
      .match_o    (raw_match[g]),
      .xlat_o     (xlat_vec[g]),
      .type_o     (type_vec[g])
    );
  end

  assign match_vec   = raw_match & {N_REGIONS{req_valid_i}};
  assign reg_rdata_o = rdata_vec[wr_rgn];

  otr_select #(.N_REGIONS(N_REGIONS), .IDX_W(IDX_W)) u_sel (
    .match_i    (match_vec),
    .xlat_i     (xlat_vec),
    .type_i     (type_vec),
    .req_addr_i (req_addr_i),
    .hit_o      (hit_o),
    .xlat_o     (xlat_addr_o),
    .type_o     (type_o),
    .idx_o      (region_o)
  );
endmodule

// File: rtl/otr_table_chk.sv
module otr_table_chk #(
  parameter int N_REGIONS = 8,
  parameter int IDX_W     = 3,
  parameter int WORD_W    = 6
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 reg_we_i,
  input logic [IDX_W-1:0]     wr_rgn,
  input logic [WORD_W-1:0]    wr_word,
  input logic [31:0]          reg_wdata_i,
  input logic                 req_valid_i,
  input logic [63:0]          req_addr_i,
  input logic                 hit_o,
  input logic [63:0]          xlat_addr_o,
  input logic [4:0]           type_o,
  input logic [IDX_W-1:0]     region_o,
  input logic [N_REGIONS-1:0] en_vec,
  input logic [N_REGIONS-1:0] match_vec
);
  logic [N_REGIONS-1:0] below_mask;
  assign below_mask = (N_REGIONS'(1) << region_o) - N_REGIONS'(1);

  // R9
  miss_passthru_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> (xlat_addr_o == req_addr_i && type_o == '0 && region_o == '0));

  // R11
  idle_no_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |-> !hit_o);

  // R4
  hit_enabled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (en_vec[region_o] && match_vec[region_o]));

  // R8
  lowest_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> ((match_vec & below_mask) == '0));

  // R3
  enable_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && wr_word == WORD_W'(1)) |=> (en_vec[$past(wr_rgn)] == $past(reg_wdata_i[31])));
endmodule

bind otr_table otr_table_chk #(.N_REGIONS(N_REGIONS), .IDX_W(IDX_W), .WORD_W(WORD_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_we_i    (reg_we_i),
  .wr_rgn      (wr_rgn),
  .wr_word     (wr_word),
  .reg_wdata_i (reg_wdata_i),
  .req_valid_i (req_valid_i),
  .req_addr_i  (req_addr_i),
  .hit_o       (hit_o),
  .xlat_addr_o (xlat_addr_o),
  .type_o      (type_o),
  .region_o    (region_o),
  .en_vec      (en_vec),
  .match_vec   (match_vec)
);

// File: tb/sim_otr_table.sv
module sim_otr_table;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [8:0]  raddr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        valid = 1'b0;
  logic [63:0] addr = '0;
  logic        hit;
  logic [63:0] xlat;
  logic [4:0]  typ;
  logic [2:0]  rgn;

  int n_run = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  otr_table u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(raddr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .req_valid_i(valid),
    .req_addr_i(addr), .hit_o(hit), .xlat_addr_o(xlat), .type_o(typ),
    .region_o(rgn)
  );

  typedef struct packed {
    logic [63:0] a;
    logic        h;
    logic [63:0] x;
    logic [2:0]  r;
    logic [4:0]  t;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VT [NV] = '{
    '{64'h0000_0000_1800_0000, 1'b1, 64'h0000_0040_0000_0000, 3'd0, 5'd0}, // R5 base
    '{64'h0000_0000_1FEF_FFFF, 1'b1, 64'h0000_0040_07EF_FFFF, 3'd0, 5'd0}, // R5 limit
    '{64'h0000_0000_17FF_FFFF, 1'b0, 64'h0000_0000_17FF_FFFF, 3'd0, 5'd0}, // R5 base-1
    '{64'h0000_0000_1FF0_0000, 1'b1, 64'h0000_0000_032A_0000, 3'd2, 5'd5}, // R6 cfg1
    '{64'h0000_0000_1FF0_1234, 1'b1, 64'h0000_0000_032A_1234, 3'd2, 5'd5}, // R6
    '{64'h0000_0000_1FF8_0004, 1'b1, 64'h0000_0000_0000_0004, 3'd1, 5'd2}, // R10 io
    '{64'h0000_0000_1FF9_0000, 1'b0, 64'h0000_0000_1FF9_0000, 3'd0, 5'd0}, // R5 limit+1
    '{64'h0000_0000_3000_0100, 1'b0, 64'h0000_0000_3000_0100, 3'd0, 5'd0}, // R4 disabled
    '{64'h0000_0003_4000_0010, 1'b1, 64'h0000_0000_7000_0010, 3'd3, 5'd4}, // R8 overlap
    '{64'h0000_0003_4000_0100, 1'b1, 64'h0000_0000_5000_0100, 3'd6, 5'd2}, // R8 past r3
    '{64'h0000_0004_4000_0000, 1'b0, 64'h0000_0004_4000_0000, 3'd0, 5'd0}, // R7 upper mismatch
    '{64'h0000_0001_0000_0000, 1'b1, 64'h0000_0100_0000_0000, 3'd5, 5'd0}, // R7 ext base
    '{64'h0000_0002_7FFF_FFFF, 1'b1, 64'h0000_0101_7FFF_FFFF, 3'd5, 5'd0}, // R7 ext limit
    '{64'h0000_0002_8000_0000, 1'b0, 64'h0000_0002_8000_0000, 3'd0, 5'd0}, // R7 ext limit+1
    '{64'h0000_0001_8000_0000, 1'b1, 64'h0000_0100_8000_0000, 3'd5, 5'd0}  // R7 ext wide
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int r, input int w, input logic [31:0] d);
    @(negedge clk);
    raddr = 9'(r * 64 + w);
    wdata = d;
    we    = 1'b1;
    @(negedge clk);
    we    = 1'b0;
  endtask

  task automatic rd_chk(input string req, input int r, input int w, input logic [31:0] exp);
    @(negedge clk);
    raddr = 9'(r * 64 + w);
    #1 chk(req, 64'(rdata), 64'(exp));
  endtask

  task automatic prog(input int r, input logic [31:0] c1, input logic [63:0] b,
                      input logic [63:0] l, input logic [63:0] t, input logic en);
    wr(r, 0, c1);
    wr(r, 2, b[31:0]);
    wr(r, 3, b[63:32]);
    wr(r, 4, l[31:0]);
    wr(r, 8, l[63:32]);
    wr(r, 5, t[31:0]);
    wr(r, 6, t[63:32]);
    wr(r, 1, {en, 31'd0});
  endtask

  task automatic look(input string req, input logic [63:0] a, input logic v,
                      input logic eh, input logic [63:0] ex, input logic [2:0] er,
                      input logic [4:0] et);
    @(negedge clk);
    addr  = a;
    valid = v;
    #1;
    chk(req, 64'(hit), 64'(eh));
    chk(req, xlat, ex);
    chk(req, 64'(rgn), 64'(er));
    chk(req, 64'(typ), 64'(et));
  endtask

  initial begin : watchdog
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    for (int r = 0; r < 8; r += 3) begin
      rd_chk("R1", r, 0, 32'h0);
      rd_chk("R1", r, 1, 32'h0);
      rd_chk("R1", r, 4, 32'h0);
    end
    look("R1", 64'h0, 1'b1, 1'b0, 64'h0, 3'd0, 5'd0);

    // R2/R3: readback and masking
    prog(7, 32'hFFFF_FFFF, 64'h1122_3344_5566_7788, 64'h99AA_BBCC_DDEE_FF00,
         64'h0102_0304_0506_0708, 1'b1);
    rd_chk("R3", 7, 0, 32'h0000_201F);
    rd_chk("R3", 7, 1, 32'h8000_0000);
    rd_chk("R2", 7, 2, 32'h5566_7788);
    rd_chk("R2", 7, 3, 32'h1122_3344);
    rd_chk("R2", 7, 4, 32'hDDEE_FF00);
    rd_chk("R2", 7, 5, 32'h0506_0708);
    rd_chk("R2", 7, 6, 32'h0102_0304);
    rd_chk("R2", 7, 8, 32'h99AA_BBCC);
    wr(7, 7, 32'hFFFF_FFFF);
    rd_chk("R3", 7, 7, 32'h0);
    wr(7, 1, 32'h7FFF_FFFF);
    rd_chk("R3", 7, 1, 32'h0);

    // table setup
    prog(0, 32'h0, 64'h1800_0000, 64'h1FEF_FFFF, 64'h0000_0040_0000_0000, 1'b1);
    prog(1, 32'h2, 64'h1FF8_0000, 64'h1FF8_FFFF, 64'h0, 1'b1);
    prog(2, 32'h5, 64'h1FF0_0000, 64'h1FF7_FFFF, 64'h032A_0000, 1'b1);
    prog(3, 32'h4, 64'h3_4000_0000, 64'h3_4000_00FF, 64'h7000_0000, 1'b1);
    prog(4, 32'h0, 64'h3000_0000, 64'h3000_FFFF, 64'h0, 1'b0);
    prog(5, 32'h2000, 64'h1_0000_0000, 64'h2_7FFF_FFFF, 64'h0000_0100_0000_0000, 1'b1);
    prog(6, 32'h2, 64'h3_4000_0000, 64'h3_4000_FFFF, 64'h5000_0000, 1'b1);

    // R5 R6 R7 R8 R9 R10: vector table
    for (int i = 0; i < NV; i++)
      look("R6", VT[i].a, 1'b1, VT[i].h, VT[i].x, VT[i].r, VT[i].t);

    // R11: valid low
    look("R11", 64'h1800_0000, 1'b0, 1'b0, 64'h1800_0000, 3'd0, 5'd0);

    // R4: disable window 0, and the same address now misses
    wr(0, 1, 32'h0);
    look("R4", 64'h1800_0000, 1'b1, 1'b0, 64'h1800_0000, 3'd0, 5'd0);
    // R8: overlap of 3 and 6, window 3 disabled, so 6 takes it
    wr(3, 1, 32'h0);
    look("R8", 64'h3_4000_0010, 1'b1, 1'b1, 64'h5000_0010, 3'd6, 5'd2);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule